// File: doc/BRIEF.md
# Local Countdown Timer with Prescaler

This block is a per-core countdown timer. A free-running bus-cycle tick strobe (`tick_i`) feeds a programmable power-of-two prescaler. The prescaled ticks decrement a current-count register that software loads through an initial-count register. When the count runs out, the block raises a one-cycle interrupt request that carries the 8-bit vector programmed in the timer's vector entry. Depending on the periodic bit, the count then reloads or stays at zero.

Software reaches four registers through a flat write/read port. Select codes are 0 for the vector entry, 1 for the initial count, 2 for the current count (read-only) and 3 for the divide configuration. The divide code is spread over bits 0, 1 and 3 of its register. A software-disable input keeps the mask bit of the vector entry set for as long as it is asserted. Interrupt acceptance and address decoding belong to the surrounding logic.

Top module: `ltmr_top`

## Requirements
- R1: A write to select 3 keeps only bits 0, 1 and 3 of the data. Every other bit of the divide register reads as zero.
- R2: With code c = {bit3, bit1, bit0}, the divisor is 2^((c+1) mod 8). Code 111 divides by 1, code 000 by 2, code 011 by 16 and code 110 by 128.
- R3: A nonzero write to select 1 arms the timer. The first expiry comes after initial count × divisor tick-qualified clock edges.
- R4: The current count (select 2) reads as the initial count minus floor(elapsed ticks / divisor). Writes to select 2 are ignored.
- R5: When bit 17 (periodic) of the vector entry is clear, the timer fires once. The current count then holds at zero until the next initial-count write.
- R6: When bit 17 is set, the count reloads from the initial count at each expiry and fires again every period.
- R7: A write to select 0 keeps bits 7:0 (vector), 12 (delivery status), 16 (mask) and 17 (periodic). All other bits read as zero.
- R8: Writing zero to select 1 does not arm the timer. It also stops a running count, and the current count reads zero.
- R9: At each expiry, `irq_o` pulses for one cycle and `irq_vec_o` shows bits 7:0 of the vector entry. While bit 16 (mask) is set, the pulse is suppressed but counting continues.
- R10: While `sw_disable_i` is high, the mask bit reads as set, both for the stored entry and for any entry written during that time.
- R11: After reset, the divide register reads 0, the initial and current counts read 0, the vector entry reads 0x0001_0000, and `irq_o` is low.
- R12: The count advances only on edges where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Bus-cycle tick qualifier |
| sw_disable_i | input | 1 | Software disable; forces the mask bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write register select |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Read register select |
| rd_data_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | One-cycle interrupt request |
| irq_vec_o | output | 8 | Vector that goes with the request |

## Verification
The assertions assume that `wr_sel_i` and `wr_data_i` matter only while `wr_en_i` is high. They also assume that `tick_i` and `sw_disable_i` are synchronous levels sampled at the clock edge. The assertion that each step of the count is a decrement or a reload holds only if the count changes in no other way than through an initial-count write. The bench drives every input half a period away from the active edge and raises the write strobe for exactly one edge. It holds `tick_i` high except in the gating scenario, so elapsed-tick counts equal edge counts.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
  typedef enum logic [1:0] {
    SEL_VEC  = 2'd0,
    SEL_INIT = 2'd1,
    SEL_CUR  = 2'd2,
    SEL_DIV  = 2'd3
  } ltmr_sel_e;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned VEC_W    = 8;
  localparam int unsigned MASK_BIT = 16;
  localparam int unsigned PER_BIT  = 17;
  localparam logic [DATA_W-1:0] VEC_KEEP   = 32'h0003_10FF;
  localparam logic [DATA_W-1:0] VEC_RESET  = 32'h0001_0000;
  localparam logic [3:0]        DIV_KEEP   = 4'hB;

  // scrambled divide code -> log2(divisor)
  function automatic logic [2:0] div_shift(input logic [3:0] cfg);
    logic [2:0] code;
    code = {cfg[3], cfg[1], cfg[0]};
    return code + 3'd1;
  endfunction
endpackage

// File: rtl/ltmr_prescale.sv
module ltmr_prescale #(
  parameter int unsigned PRE_W = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       restart_i,
  input  logic [2:0] shift_i,
  output logic       pre_tick_o
);
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] limit;
  logic [PRE_W-1:0] pre_q;

  assign span  = (PRE_W+1)'(1) << shift_i;
  assign limit = PRE_W'(span - (PRE_W+1)'(1));
  // >= keeps a shrinking divisor from stranding the prescaler above its limit
  assign pre_tick_o = tick_i && !restart_i && (pre_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pre_q <= '0;
    else if (restart_i)   pre_q <= '0;
    else if (pre_tick_o)  pre_q <= '0;
    else if (tick_i)      pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/ltmr_count.sv
module ltmr_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             pre_tick_i,
  input  logic             periodic_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] init_o,
  output logic [CNT_W-1:0] cur_o
);
  logic [CNT_W-1:0] init_q, cur_q;
  logic             armed_q;

  assign expire_o = armed_q && pre_tick_i && !load_i && (cur_q == CNT_W'(1));
  assign init_o   = init_q;
  assign cur_o    = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q  <= '0;
      cur_q   <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      init_q  <= load_val_i;
      cur_q   <= load_val_i;
      armed_q <= (load_val_i != '0);
    end else if (expire_o) begin
      cur_q   <= periodic_i ? init_q : '0;
      armed_q <= periodic_i;
    end else if (armed_q && pre_tick_i) begin
      cur_q   <= cur_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/ltmr_vec_entry.sv
module ltmr_vec_entry
  import ltmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sw_disable_i,
  output logic [DATA_W-1:0] entry_o
);
  logic [DATA_W-1:0] entry_q;
  logic [DATA_W-1:0] force_mask;

  assign force_mask = sw_disable_i ? (DATA_W'(1) << MASK_BIT) : '0;
  assign entry_o    = entry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    entry_q <= VEC_RESET;
    else if (wr_i)  entry_q <= (wr_data_i & VEC_KEEP) | force_mask;
    else            entry_q <= entry_q | force_mask;
  end
endmodule

// File: rtl/ltmr_top.sv
module ltmr_top
  import ltmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sw_disable_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  logic              wr_vec, wr_init, wr_div;
  logic [3:0]        div_cfg_q;
  logic [DATA_W-1:0] lvt_entry;
  logic              pre_tick, expire;
  logic [CNT_W-1:0]  init_cnt, cur_cnt;

  assign wr_vec  = wr_en_i && (wr_sel_i == SEL_VEC);
  assign wr_init = wr_en_i && (wr_sel_i == SEL_INIT);
  assign wr_div  = wr_en_i && (wr_sel_i == SEL_DIV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_cfg_q <= '0;
    else if (wr_div) div_cfg_q <= wr_data_i[3:0] & DIV_KEEP;
  end

  ltmr_vec_entry u_vec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_vec),
    .wr_data_i    (wr_data_i),
    .sw_disable_i (sw_disable_i),
    .entry_o      (lvt_entry)
  );

  ltmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .restart_i  (wr_init),
    .shift_i    (div_shift(div_cfg_q)),
    .pre_tick_o (pre_tick)
  );

  ltmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_init),
    .load_val_i (CNT_W'(wr_data_i)),
    .pre_tick_i (pre_tick),
    .periodic_i (lvt_entry[PER_BIT]),
    .expire_o   (expire),
    .init_o     (init_cnt),
    .cur_o      (cur_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      irq_vec_o <= '0;
    end else begin
      irq_o <= expire && !lvt_entry[MASK_BIT];
      if (expire) irq_vec_o <= lvt_entry[VEC_W-1:0];
    end
  end

  always_comb begin
    unique case (rd_sel_i)
      SEL_VEC:  rd_data_o = lvt_entry;
      SEL_INIT: rd_data_o = DATA_W'(init_cnt);
      SEL_CUR:  rd_data_o = DATA_W'(cur_cnt);
      default:  rd_data_o = DATA_W'(div_cfg_q);
    endcase
  end
endmodule

// File: rtl/ltmr_checker.sv
module ltmr_checker
  import ltmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              sw_disable_i,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic [1:0]        rd_sel_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              irq_o,
  input logic [VEC_W-1:0]  irq_vec_o,
  input logic [DATA_W-1:0] entry,
  input logic [CNT_W-1:0]  cur
);
  logic init_wr;
  assign init_wr = wr_en_i && (wr_sel_i == SEL_INIT);

  a_r9_irq_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(entry[MASK_BIT]));

  a_r9_irq_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_vec_o == $past(entry[VEC_W-1:0])));

  a_r12_irq_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_i));

  a_r1_div_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == SEL_DIV) |-> ((rd_data_o & ~32'h0000_000B) == '0));

  a_r10_disable_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sw_disable_i) |-> entry[MASK_BIT]);

  a_r5_zero_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cur == '0) && !init_wr) |=> (cur == '0));

  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(init_wr) && (cur != $past(cur)))
      |-> (($past(cur) == CNT_W'(1)) || (cur == $past(cur) - CNT_W'(1))));
endmodule

bind ltmr_top ltmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .sw_disable_i (sw_disable_i),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .rd_sel_i     (rd_sel_i),
  .rd_data_o    (rd_data_o),
  .irq_o        (irq_o),
  .irq_vec_o    (irq_vec_o),
  .entry        (lvt_entry),
  .cur          (cur_cnt)
);

// File: tb/sim_ltmr_top.sv
module sim_ltmr_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] S_VEC = 2'd0, S_INIT = 2'd1, S_CUR = 2'd2, S_DIV = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        sw_dis = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        irq;
  logic [7:0]  irq_vec;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ltmr_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sw_disable_i(sw_dis),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .irq_o(irq), .irq_vec_o(irq_vec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    rd_sel = sel;
    #1;
    d = rd_data;
  endtask

  // edges after the last write until irq seen, -1 on timeout
  task automatic wait_irq(input int limit, output int n);
    n = 0;
    forever begin
      @(posedge clk); n++;
      @(negedge clk);
      if (irq) break;
      if (n >= limit) begin n = -1; break; end
    end
  endtask

  task automatic count_irqs(input int edges, output int hits);
    hits = 0;
    for (int i = 0; i < edges; i++) begin
      @(posedge clk); @(negedge clk);
      if (irq) hits++;
    end
  endtask

  function automatic int exp_div(input logic [3:0] cfg);
    int c;
    c = {cfg[3], cfg[1], cfg[0]};
    return 1 << ((c + 1) % 8);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(S_DIV, d);  check("R11 div reset", d, 32'h0);
    rd(S_INIT, d); check("R11 init reset", d, 32'h0);
    rd(S_CUR, d);  check("R11 cur reset", d, 32'h0);
    rd(S_VEC, d);  check("R11 vec reset", d, 32'h0001_0000);
    check("R11 irq reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_div_bits();
    logic [31:0] d;
    wr(S_DIV, 32'hFFFF_FFFF);
    rd(S_DIV, d); check("R1 div writable bits", d, 32'h0000_000B);
    wr(S_DIV, 32'hFFFF_FFF4);
    rd(S_DIV, d); check("R1 div other bits", d, 32'h0);
  endtask

  task automatic t_vec_fields();
    logic [31:0] d;
    wr(S_VEC, 32'hFFFF_FFFF);
    rd(S_VEC, d); check("R7 vec field keep", d, 32'h0003_10FF);
    wr(S_VEC, 32'h0000_EF00);
    rd(S_VEC, d); check("R7 vec drop", d, 32'h0000_0000);
  endtask

  task automatic t_divisors();
    logic [3:0] cfgs [4] = '{4'hB, 4'h0, 4'h3, 4'hA};
    int n, hits;
    logic [31:0] d;
    wr(S_VEC, 32'h0000_0040);
    foreach (cfgs[i]) begin
      wr(S_DIV, {28'b0, cfgs[i]});
      wr(S_INIT, 32'd3);
      wait_irq(2000, n);
      check($sformatf("R2 R3 expiry edges cfg=%h", cfgs[i]), n, 3 * exp_div(cfgs[i]));
      check("R9 irq vector", {24'b0, irq_vec}, 32'h40);
      @(posedge clk); @(negedge clk);
      check("R9 one-cycle pulse", {31'b0, irq}, 32'h0);
    end
    count_irqs(20, hits);
    check("R5 one-shot no refire", hits, 0);
    rd(S_CUR, d); check("R5 cur holds zero", d, 32'h0);
  endtask

  task automatic t_cur_value();
    logic [31:0] d;
    wr(S_DIV, 32'h0);
    wr(S_INIT, 32'd10);
    repeat (5) @(posedge clk);
    #1;
    rd(S_CUR, d); check("R4 cur after 5 edges div2", d, 32'd8);
    wr(S_CUR, 32'd1234);
    rd(S_CUR, d); check("R4 cur write ignored", d, 32'd7);
    wr(S_INIT, 32'h0);
  endtask

  task automatic t_periodic();
    int n1, n2;
    logic [31:0] d;
    wr(S_VEC, 32'h0002_0055);
    wr(S_DIV, 32'hB);
    wr(S_INIT, 32'd4);
    wait_irq(100, n1);
    check("R6 first period", n1, 4);
    check("R6 vector", {24'b0, irq_vec}, 32'h55);
    n2 = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); n2++;
      @(negedge clk);
      if (irq) break;
    end
    check("R6 second period", n2, 4);
    rd(S_CUR, d); check("R6 reloaded", d, 32'd4);
    wr(S_INIT, 32'h0);
  endtask

  task automatic t_masked();
    int hits;
    logic [31:0] d;
    wr(S_VEC, 32'h0003_0021);
    wr(S_DIV, 32'hB);
    wr(S_INIT, 32'd5);
    count_irqs(12, hits);
    check("R9 masked no irq", hits, 0);
    rd(S_CUR, d); check("R9 masked keeps counting", d, 32'd3);
    wr(S_INIT, 32'h0);
  endtask

  task automatic t_zero_init();
    int hits;
    logic [31:0] d;
    wr(S_VEC, 32'h0000_0033);
    wr(S_DIV, 32'hB);
    wr(S_INIT, 32'd100);
    repeat (10) @(posedge clk);
    wr(S_INIT, 32'h0);
    rd(S_CUR, d); check("R8 zero stops count", d, 32'h0);
    count_irqs(200, hits);
    check("R8 zero no irq", hits, 0);
  endtask

  task automatic t_tick_gate();
    logic [31:0] d;
    wr(S_DIV, 32'hB);
    @(negedge clk); tick = 1'b0;
    wr(S_INIT, 32'd7);
    repeat (10) @(posedge clk);
    #1;
    rd(S_CUR, d); check("R12 no tick holds", d, 32'd7);
    @(negedge clk); tick = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rd(S_CUR, d); check("R12 tick resumes", d, 32'd4);
    wr(S_INIT, 32'h0);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wr(S_VEC, 32'h0000_0040);
    @(negedge clk); sw_dis = 1'b1;
    @(posedge clk); #1;
    rd(S_VEC, d); check("R10 stored entry masked", d, 32'h0001_0040);
    wr(S_VEC, 32'h0000_0041);
    rd(S_VEC, d); check("R10 write while disabled", d, 32'h0001_0041);
    @(negedge clk); sw_dis = 1'b0;
    wr(S_VEC, 32'h0000_0042);
    rd(S_VEC, d); check("R10 released", d, 32'h0000_0042);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_div_bits();
    t_vec_fields();
    t_divisors();
    t_cur_value();
    t_periodic();
    t_masked();
    t_zero_init();
    t_tick_gate();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule